// File: doc/BRIEF.md
# Page Translation Buffer with Privilege-Aware Rights Check

This block caches recent virtual-to-physical page mappings for a demand-paged memory system that uses 4-Kbyte pages. It has eight fully associative entries. Each access presents a 32-bit virtual address, a read/write flag and a privilege flag (user or supervisor). One clock later the block returns a registered response. On a hit the response carries the physical address, built from the cached frame number and the untranslated low 12 address bits. On a miss it raises a miss flag. When the cached rights deny the access it raises a fault flag.

Each entry holds a page number, a frame number, a valid bit and a 2-bit rights code. The rights code is decoded differently in the two privilege modes. A supervisor can always read a mapped page. A user can be refused entirely. A refill port writes one entry per cycle into the slot chosen by a round-robin pointer. A flush input invalidates every entry in one cycle. Page-table walks and fault handling are left to the surrounding system.

Top module: `tlb_rights`

## Requirements
- R1: After synchronous reset all response outputs are zero and every entry is invalid, so the first lookup misses.
- R2: A lookup whose address bits [31:12] match a valid entry gives, on the next cycle, rsp_hit=1 and, if permitted, rsp_pa_valid=1 with rsp_paddr = {frame, vaddr[11:0]}.
- R3: A lookup with no matching valid entry gives, on the next cycle, rsp_miss=1, rsp_hit=0, rsp_fault=0, rsp_pa_valid=0 and rsp_paddr=0.
- R4: In user mode (req_super=0) the rights codes mean: 2'b00 and 2'b01 no access, 2'b10 read only, 2'b11 read and write.
- R5: In supervisor mode (req_super=1) rights 2'b00 means read only and 2'b01, 2'b10, 2'b11 mean read and write, so a supervisor read of a hit never faults.
- R6: A hit that the rights deny (any access to a no-access page, or a write, req_write=1, to a read-only page) gives rsp_hit=1, rsp_fault=1, rsp_pa_valid=0 and rsp_paddr=0.
- R7: Each refill writes page, frame and rights into the slot under a round-robin pointer and sets its valid bit. The pointer starts at slot 0 after reset, advances by one per refill and wraps from 7 to 0, so the ninth refill replaces the first.
- R8: A flush clears all valid bits in one cycle. When flush and refill arrive in the same cycle, flush wins: the refill is dropped and the pointer does not move.
- R9: A lookup presented in the same cycle as a refill or a flush is answered from the entry contents held before that cycle.
- R10: A cycle without req_valid produces rsp_valid=0 and all response flags and the address at zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address of the access |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| flush | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Refill one entry this cycle |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_rights | input | 2 | Rights code to install |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_fault | output | 1 | Hit, but rights deny the access |
| rsp_pa_valid | output | 1 | Physical address is usable |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The assertions assume that no page number is installed twice without a flush between, so at most one entry can match any address. The bench keeps every refilled page number distinct from the ones still live. A flush is issued before any page number is reused. With this assumption the one-hot match check and the hit/miss exclusivity hold. The response checks are compared on every clock against a behavioural model of the entries and the pointer. That model also covers the cycles where a lookup coincides with a refill or a flush.

// File: rtl/tlb_rights_pkg.sv
package tlb_rights_pkg;

    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PFN_W     = PA_W - PAGE_BITS;

    typedef logic [1:0] rights_t;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        rights_t          rights;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RO   = 2'd1,
        ACC_RW   = 2'd2
    } access_e;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        logic            fault;
        logic            pa_valid;
        logic [PA_W-1:0] paddr;
    } tlb_rsp_t;

    // Supervisor always keeps read access; user can be locked out.
    function automatic access_e decode_rights(rights_t r, logic super_mode);
        access_e a;
        if (super_mode) begin
            a = (r == 2'b00) ? ACC_RO : ACC_RW;
        end else begin
            case (r)
                2'b11:   a = ACC_RW;
                2'b10:   a = ACC_RO;
                default: a = ACC_NONE;
            endcase
        end
        return a;
    endfunction

    function automatic logic access_ok(access_e a, logic is_write);
        logic ok;
        case (a)
            ACC_RW:  ok = 1'b1;
            ACC_RO:  ok = ~is_write;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_rights_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   fill_valid,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PFN_W-1:0]       fill_pfn,
    input  rights_t                fill_rights,
    output tlb_entry_t [ENTRIES-1:0] entries
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    tlb_entry_t       slot_q [ENTRIES];
    logic [PTR_W-1:0] ptr_q;
    logic             do_fill;

    assign do_fill = fill_valid & ~flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                slot_q[i] <= '0;
            end
            ptr_q <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                slot_q[i].valid <= 1'b0;
            end
        end else if (do_fill) begin
            slot_q[ptr_q] <= '{valid: 1'b1, vpn: fill_vpn, pfn: fill_pfn, rights: fill_rights};
            ptr_q         <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_out
            assign entries[g] = slot_q[g];
        end
    endgenerate

    logic [ENTRIES-1:0] valid_vec;
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            valid_vec[i] = slot_q[i].valid;
        end
    end

    // R8: one cycle after a flush nothing is valid
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

    // R7: a refill lands valid in the slot the pointer held
    a_r7_fill_lands: assert property (@(posedge clk) disable iff (rst)
        do_fill |=> (slot_q[$past(ptr_q)].valid && slot_q[$past(ptr_q)].vpn == $past(fill_vpn)));

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_rights_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  tlb_entry_t [ENTRIES-1:0] entries,
    input  logic [VPN_W-1:0]         vpn,
    output logic [ENTRIES-1:0]       match,
    output logic                     hit,
    output tlb_entry_t               sel
);

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = entries[g].valid && (entries[g].vpn == vpn);
        end
    endgenerate

    assign hit = |match;

    // lowest matching slot wins
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel = entries[i];
        end
    end

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_rights_pkg::*;
(
    input  rights_t rights,
    input  logic    super_mode,
    input  logic    is_write,
    output access_e level,
    output logic    allow
);

    assign level = decode_rights(rights, super_mode);
    assign allow = access_ok(level, is_write);

endmodule

// File: rtl/tlb_rights.sv
module tlb_rights
    import tlb_rights_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_super,
    input  logic             flush,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [1:0]       fill_rights,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic             rsp_pa_valid,
    output logic [PA_W-1:0]  rsp_paddr
);

    tlb_entry_t [ENTRIES-1:0] entries;
    logic [ENTRIES-1:0]       match;
    logic                     hit;
    tlb_entry_t               sel;
    access_e                  level;
    logic                     allow;
    tlb_rsp_t                 rsp_q;
    logic [VPN_W-1:0]         req_vpn;
    logic [PAGE_BITS-1:0]     req_off;

    assign req_vpn = req_vaddr[VA_W-1:PAGE_BITS];
    assign req_off = req_vaddr[PAGE_BITS-1:0];

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .fill_valid  (fill_valid),
        .fill_vpn    (fill_vpn),
        .fill_pfn    (fill_pfn),
        .fill_rights (fill_rights),
        .entries     (entries)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .entries (entries),
        .vpn     (req_vpn),
        .match   (match),
        .hit     (hit),
        .sel     (sel)
    );

    tlb_perm u_perm (
        .rights     (sel.rights),
        .super_mode (req_super),
        .is_write   (req_write),
        .level      (level),
        .allow      (allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid    <= req_valid;
            rsp_q.hit      <= req_valid & hit;
            rsp_q.miss     <= req_valid & ~hit;
            rsp_q.fault    <= req_valid & hit & ~allow;
            rsp_q.pa_valid <= req_valid & hit & allow;
            rsp_q.paddr    <= (req_valid & hit & allow) ? {sel.pfn, req_off} : '0;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_miss     = rsp_q.miss;
    assign rsp_fault    = rsp_q.fault;
    assign rsp_pa_valid = rsp_q.pa_valid;
    assign rsp_paddr    = rsp_q.paddr;

    // R2: at most one entry matches (distinct pages assumed)
    a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R3: a miss never faults and never yields an address
    a_r3_miss_clean: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (!rsp_fault && !rsp_pa_valid && rsp_paddr == '0));

    // R6: a fault suppresses the address
    a_r6_fault_blocks: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_hit && !rsp_pa_valid && rsp_paddr == '0));

    // R5: supervisor read of a present page is always granted
    a_r5_super_reads: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_super && !req_write && hit) |=> (rsp_pa_valid && !rsp_fault));

    // R10: no request, quiet response
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault && !rsp_pa_valid));

endmodule

// File: tb/tlb_rights_tb.sv
module tlb_rights_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_super, flush, fill_valid;
    logic [31:0] req_vaddr;
    logic [19:0] fill_vpn, fill_pfn;
    logic [1:0]  fill_rights;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa_valid;
    logic [31:0] rsp_paddr;

    int n_chk  = 0;
    int n_fail = 0;

    // behavioural model state
    int m_vpn [8];
    int m_pfn [8];
    int m_rt  [8];
    bit m_vld [8];
    int m_ptr;

    always #5 clk = ~clk;

    tlb_rights u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_super(req_super), .flush(flush),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_rights(fill_rights), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa_valid(rsp_pa_valid),
        .rsp_paddr(rsp_paddr)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit permitted(int r, bit sup, bit wr);
        if (sup) return (r != 0) || !wr;
        if (r == 3) return 1;
        if (r == 2) return !wr;
        return 0;
    endfunction

    task automatic cyc(input bit rv, input logic [31:0] va, input bit wr, input bit sup,
                       input bit fl, input bit fv, input int fvpn, input int fpfn,
                       input int frt, input string tag);
        bit e_hit, e_ok;
        int idx;
        logic [31:0] e_pa;
        @(negedge clk);
        req_valid = rv; req_vaddr = va; req_write = wr; req_super = sup;
        flush = fl; fill_valid = fv; fill_vpn = fvpn[19:0]; fill_pfn = fpfn[19:0];
        fill_rights = frt[1:0];
        e_hit = 0; idx = 0;
        for (int i = 7; i >= 0; i--) begin
            if (m_vld[i] && m_vpn[i] == int'(va[31:12])) begin e_hit = 1; idx = i; end
        end
        e_ok = e_hit && permitted(m_rt[idx], sup, wr);
        e_pa = (rv && e_ok) ? {m_pfn[idx][19:0], va[11:0]} : 32'h0;
        if (fl) begin
            for (int i = 0; i < 8; i++) m_vld[i] = 0;
        end else if (fv) begin
            m_vpn[m_ptr] = fvpn; m_pfn[m_ptr] = fpfn; m_rt[m_ptr] = frt; m_vld[m_ptr] = 1;
            m_ptr = (m_ptr + 1) % 8;
        end
        @(posedge clk); #1;
        check(tag, "rsp_valid",    32'(rsp_valid),    32'(rv));
        check(tag, "rsp_hit",      32'(rsp_hit),      32'(rv && e_hit));
        check(tag, "rsp_miss",     32'(rsp_miss),     32'(rv && !e_hit));
        check(tag, "rsp_fault",    32'(rsp_fault),    32'(rv && e_hit && !e_ok));
        check(tag, "rsp_pa_valid", 32'(rsp_pa_valid), 32'(rv && e_ok));
        check(tag, "rsp_paddr",    rsp_paddr,         e_pa);
    endtask

    task automatic lookup(input logic [31:0] va, input bit wr, input bit sup, input string tag);
        cyc(1, va, wr, sup, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic refill(input int vpn, input int pfn, input int rt, input string tag);
        cyc(0, 32'h0, 0, 0, 0, 1, vpn, pfn, rt, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_vpn[i] = 0; m_pfn[i] = 0; m_rt[i] = 0; m_vld[i] = 0; end
        m_ptr = 0;
        rst = 1; req_valid = 0; req_vaddr = 0; req_write = 0; req_super = 0;
        flush = 0; fill_valid = 0; fill_vpn = 0; fill_pfn = 0; fill_rights = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state of the outputs
        check("R1", "rsp_valid", 32'(rsp_valid), 0);
        check("R1", "rsp_hit",   32'(rsp_hit),   0);
        check("R1", "rsp_paddr", rsp_paddr,      0);
        @(negedge clk); rst = 0;
        lookup(32'h0000_0abc, 0, 1, "R1");          // empty after reset
        cyc(0, 32'hffff_ffff, 1, 1, 0, 0, 0, 0, 0, "R10");
        lookup(32'h1234_5678, 0, 0, "R3");
        // R9: lookup of page 0x100 together with its own refill sees the old (empty) state
        cyc(1, 32'h0010_0444, 0, 1, 0, 1, 32'h100, 32'ha00, 0, "R9");
        for (int i = 1; i < 8; i++) refill(32'h100 + i, 32'ha00 + 3 * i, i % 4, "R7");
        // R4 R5 R6: every rights code in both modes, read and write
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 4; m++) begin
                bit sup = m[1];
                bit wr  = m[0];
                string tg;
                if (!permitted(i % 4, sup, wr)) tg = "R6";
                else if (sup) tg = "R5";
                else tg = "R4";
                lookup({12'h001, 8'(i), 12'(37 * i + m)}, wr, sup, tg);
            end
        end
        // R2: translation with a range of offsets
        for (int i = 0; i < 8; i++) lookup({12'h001, 8'(i), 12'hfff - 12'(i)}, 0, 1, "R2");
        cyc(0, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R10");
        // R7: ninth refill wraps onto slot 0
        refill(32'h200, 32'h777, 3, "R7");
        lookup(32'h0010_0000, 0, 1, "R7");
        lookup(32'h0020_0123, 1, 0, "R7");
        lookup(32'h0010_1555, 0, 1, "R7");
        // R9: lookup in the flush cycle still hits
        cyc(1, 32'h0010_3010, 0, 1, 1, 0, 0, 0, 0, "R9");
        lookup(32'h0010_3010, 0, 1, "R8");
        lookup(32'h0020_0123, 0, 1, "R8");
        // R8: flush beats refill in the same cycle
        cyc(0, 32'h0, 0, 0, 1, 1, 32'h300, 32'h333, 3, "R8");
        lookup(32'h0030_0001, 0, 1, "R8");
        refill(32'h400, 32'h444, 2, "R8");
        lookup(32'h0040_0008, 0, 0, "R8");
        lookup(32'h0040_0008, 1, 0, "R6");
        cyc(0, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule